// File: doc/BRIEF.md
# Exception Entry Vector Unit

This unit performs the register side of taking an exception in a processor core. When the upstream arbiter pulses the raise strobe together with an exception code, the unit does all of the entry work in one clock edge. It copies the live status word, the faulting instruction address and general register 15 into three shadow registers. It produces the new status word with the privilege, bank-select and interrupt-block bits forced high. It records the event code, trimmed to its architectural width. It loads the next program counter from a vector target.

The vector target depends on the full raised code. The three translation-miss style codes go to a dedicated offset above the vector base. The multiple-hit code ignores the vector base and jumps to a fixed absolute address. Every other code goes to the general offset above the vector base. Choosing which exception to raise, and returning from an exception, are left to neighbouring logic.

Top module: `exc_entry_unit`

## Requirements
- R1: While and after reset (rst_n low), sr_o, pc_o, ssr_o, spc_o, sgr_o, evt_o and taken_o are all zero.
- R2: On a clock edge with raise_i high, ssr_o takes sr_i, spc_o takes pc_i and sgr_o takes r15_i, all visible from that edge.
- R3: On the same edge, sr_o becomes sr_i with bit 30 (privileged mode), bit 29 (register bank) and bit 28 (block interrupts) set to 1, and all other bits unchanged.
- R4: On the same edge, evt_o (11 bits) takes code_i[10:0], so code 0x840 records 0x040.
- R5: For code_i equal to 0x040, 0x060 or 0x080, pc_o becomes vbr_i + 0x400, modulo 2^32.
- R6: For code_i equal to 0x140, pc_o becomes 0xA000_0000 whatever vbr_i holds.
- R7: For any other 12-bit code, pc_o becomes vbr_i + 0x100. This includes 0x0E0, 0x100, 0x120, 0x160, 0x180, 0x1A0, 0x800, 0x820, and also 0x840, whose low 11 bits alone would match a miss code.
- R8: An entry is performed even when bit 28 of sr_i is already 1.
- R9: On an edge with raise_i low, none of the six data outputs changes, whatever the other inputs do.
- R10: taken_o is 1 for exactly the cycle after each edge with raise_i high, and is otherwise 0. Back-to-back raises give one result per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| raise_i | input | 1 | Exception entry strobe |
| code_i | input | 12 | Raised exception code |
| sr_i | input | 32 | Current status word |
| pc_i | input | 32 | Address of the faulting instruction |
| vbr_i | input | 32 | Vector base |
| r15_i | input | 32 | Current general register 15 |
| sr_o | output | 32 | Status word after entry |
| pc_o | output | 32 | Next program counter (vector target) |
| ssr_o | output | 32 | Saved status |
| spc_o | output | 32 | Saved program counter |
| sgr_o | output | 32 | Saved register 15 |
| evt_o | output | 11 | Recorded event code |
| taken_o | output | 1 | One-cycle pulse marking a completed entry |

## Verification
Every code in the general list, the three miss codes and the multiple-hit code are raised with distinct non-zero vector bases. This tells the two offsets and the absolute target apart, and shows that the base is dropped only for the multiple-hit code. Codes with bit 11 set (0x840, 0xFFF) separate event masking from target selection. Status words with the forced bits clear, already set and mixed with other bits show that only the three bits change and that a set block bit does not suppress entry. Back-to-back raises and idle stretches with changing inputs separate per-cycle capture from holding.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [1:0] {
    VK_GENERAL = 2'd0,
    VK_TLB     = 2'd1,
    VK_FIXED   = 2'd2
  } vec_kind_e;

endpackage

// File: rtl/exc_vec_classify.sv
module exc_vec_classify
  import exc_entry_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int N_TLB  = 3,
  parameter logic [N_TLB*CODE_W-1:0] TLB_CODES = {12'h080, 12'h060, 12'h040},
  parameter logic [CODE_W-1:0] FIXED_CODE = 12'h140
) (
  input  logic [CODE_W-1:0] code_i,
  output vec_kind_e         kind_o
);

  logic [N_TLB-1:0] tlb_hit;

  generate
    for (genvar gi = 0; gi < N_TLB; gi++) begin : g_tlb_match
      assign tlb_hit[gi] = (code_i == TLB_CODES[gi*CODE_W +: CODE_W]);
    end
  endgenerate

  always_comb begin
    if (code_i == FIXED_CODE) begin
      kind_o = VK_FIXED;
    end else if (|tlb_hit) begin
      kind_o = VK_TLB;
    end else begin
      kind_o = VK_GENERAL;
    end
  end

endmodule

// File: rtl/exc_target_gen.sv
module exc_target_gen
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] TLB_OFS   = 32'h0000_0400,
  parameter logic [XLEN-1:0] GEN_OFS   = 32'h0000_0100,
  parameter logic [XLEN-1:0] FIXED_TGT = 32'hA000_0000
) (
  input  vec_kind_e       kind_i,
  input  logic [XLEN-1:0] vbr_i,
  output logic [XLEN-1:0] target_o
);

  logic [XLEN-1:0] ofs;

  always_comb begin
    ofs = (kind_i == VK_TLB) ? TLB_OFS : GEN_OFS;
    if (kind_i == VK_FIXED) begin
      target_o = FIXED_TGT;
    end else begin
      target_o = vbr_i + ofs;
    end
  end

endmodule

// File: rtl/exc_sr_force.sv
module exc_sr_force #(
  parameter int XLEN   = 32,
  parameter int MD_POS = 30,
  parameter int RB_POS = 29,
  parameter int BL_POS = 28
) (
  input  logic [XLEN-1:0] sr_i,
  output logic [XLEN-1:0] sr_o
);

  localparam logic [XLEN-1:0] FORCE_MASK =
    (XLEN'(1) << MD_POS) | (XLEN'(1) << RB_POS) | (XLEN'(1) << BL_POS);

  assign sr_o = sr_i | FORCE_MASK;

endmodule

// File: rtl/exc_shadow_reg.sv
module exc_shadow_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_o;
    if (en_i) begin
      q_nxt = d_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= '0;
    end else begin
      q_o <= q_nxt;
    end
  end

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 12,
  parameter int EVT_W  = 11,
  parameter int MD_POS = 30,
  parameter int RB_POS = 29,
  parameter int BL_POS = 28,
  parameter logic [XLEN-1:0] TLB_OFS   = 32'h0000_0400,
  parameter logic [XLEN-1:0] GEN_OFS   = 32'h0000_0100,
  parameter logic [XLEN-1:0] FIXED_TGT = 32'hA000_0000,
  parameter logic [CODE_W-1:0] FIXED_CODE = 12'h140
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raise_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   vbr_i,
  input  logic [XLEN-1:0]   r15_i,
  output logic [XLEN-1:0]   sr_o,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   sgr_o,
  output logic [EVT_W-1:0]  evt_o,
  output logic              taken_o
);

  localparam int N_TLB = 3;
  localparam logic [N_TLB*CODE_W-1:0] TLB_CODES =
    {CODE_W'(12'h080), CODE_W'(12'h060), CODE_W'(12'h040)};

  vec_kind_e         kind;
  logic [XLEN-1:0]   target;
  logic [XLEN-1:0]   sr_forced;
  logic [EVT_W-1:0]  evt_d;
  logic              taken_nxt;

  exc_vec_classify #(
    .CODE_W(CODE_W), .N_TLB(N_TLB), .TLB_CODES(TLB_CODES), .FIXED_CODE(FIXED_CODE)
  ) u_classify (
    .code_i(code_i), .kind_o(kind)
  );

  exc_target_gen #(
    .XLEN(XLEN), .TLB_OFS(TLB_OFS), .GEN_OFS(GEN_OFS), .FIXED_TGT(FIXED_TGT)
  ) u_target (
    .kind_i(kind), .vbr_i(vbr_i), .target_o(target)
  );

  exc_sr_force #(
    .XLEN(XLEN), .MD_POS(MD_POS), .RB_POS(RB_POS), .BL_POS(BL_POS)
  ) u_force (
    .sr_i(sr_i), .sr_o(sr_forced)
  );

  assign evt_d = code_i[EVT_W-1:0];

  exc_shadow_reg #(.W(XLEN)) u_ssr (
    .clk(clk), .rst_n(rst_n), .en_i(raise_i), .d_i(sr_i), .q_o(ssr_o));
  exc_shadow_reg #(.W(XLEN)) u_spc (
    .clk(clk), .rst_n(rst_n), .en_i(raise_i), .d_i(pc_i), .q_o(spc_o));
  exc_shadow_reg #(.W(XLEN)) u_sgr (
    .clk(clk), .rst_n(rst_n), .en_i(raise_i), .d_i(r15_i), .q_o(sgr_o));
  exc_shadow_reg #(.W(XLEN)) u_sr (
    .clk(clk), .rst_n(rst_n), .en_i(raise_i), .d_i(sr_forced), .q_o(sr_o));
  exc_shadow_reg #(.W(XLEN)) u_pc (
    .clk(clk), .rst_n(rst_n), .en_i(raise_i), .d_i(target), .q_o(pc_o));
  exc_shadow_reg #(.W(EVT_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .en_i(raise_i), .d_i(evt_d), .q_o(evt_o));

  assign taken_nxt = raise_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_o <= 1'b0;
    end else begin
      taken_o <= taken_nxt;
    end
  end

  AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    raise_i |=> (ssr_o == $past(sr_i)) && (spc_o == $past(pc_i)) && (sgr_o == $past(r15_i))); // R2
  AST_MODE_BITS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    raise_i |=> sr_o[MD_POS] && sr_o[RB_POS] && sr_o[BL_POS]); // R3
  AST_EVT_TRIMMED: assert property (@(posedge clk) disable iff (!rst_n)
    raise_i |=> evt_o == $past(code_i[EVT_W-1:0])); // R4
  AST_FIXED_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_i && code_i == FIXED_CODE) |=> pc_o == FIXED_TGT); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !raise_i |=> $stable(sr_o) && $stable(pc_o) && $stable(ssr_o)
                 && $stable(spc_o) && $stable(sgr_o) && $stable(evt_o)); // R9
  AST_TAKEN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    raise_i |=> taken_o); // R10

endmodule

// File: tb/exc_entry_unit_tb_top.sv
module exc_entry_unit_tb_top;

  typedef struct {
    logic [31:0] sr, pc, ssr, spc, sgr;
    logic [10:0] evt;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        raise_i;
  logic [11:0] code_i;
  logic [31:0] sr_i, pc_i, vbr_i, r15_i;
  logic [31:0] sr_o, pc_o, ssr_o, spc_o, sgr_o;
  logic [10:0] evt_o;
  logic        taken_o;

  int   checks = 0;
  int   errors = 0;
  exp_t sb_q[$];
  exp_t last;

  always #5 clk = ~clk;

  exc_entry_unit dut_i (
    .clk(clk), .rst_n(rst_n), .raise_i(raise_i), .code_i(code_i),
    .sr_i(sr_i), .pc_i(pc_i), .vbr_i(vbr_i), .r15_i(r15_i),
    .sr_o(sr_o), .pc_o(pc_o), .ssr_o(ssr_o), .spc_o(spc_o),
    .sgr_o(sgr_o), .evt_o(evt_o), .taken_o(taken_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_target(input logic [11:0] c, input logic [31:0] v);
    if (c == 12'h140) return 32'hA000_0000;                        // R6
    if (c == 12'h040 || c == 12'h060 || c == 12'h080) return v + 32'h400; // R5
    return v + 32'h100;                                           // R7
  endfunction

  task automatic raise(input logic [11:0] c, input logic [31:0] s, input logic [31:0] p,
                       input logic [31:0] v, input logic [31:0] r, input string tag);
    exp_t e;
    @(negedge clk);
    raise_i = 1'b1; code_i = c; sr_i = s; pc_i = p; vbr_i = v; r15_i = r;
    e.sr  = s | 32'h7000_0000;
    e.pc  = ref_target(c, v);
    e.ssr = s; e.spc = p; e.sgr = r;
    e.evt = c[10:0];
    e.tag = tag;
    sb_q.push_back(e);
    last = e;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      raise_i = 1'b0;
      code_i = 12'h040 + 12'(i); sr_i = ~sr_i; pc_i = pc_i + 32'h44;
      vbr_i = vbr_i ^ 32'h0F0F_0000; r15_i = r15_i + 32'h1;
    end
  endtask

  // monitor: compare each completed entry against the scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1 && taken_o === 1'b1) begin
      exp_t e;
      if (sb_q.size() == 0) begin
        chk("R10 unexpected taken", 32'd1, 32'd0);
      end else begin
        e = sb_q.pop_front();
        chk({"R2 ssr ", e.tag}, ssr_o, e.ssr);
        chk({"R2 spc ", e.tag}, spc_o, e.spc);
        chk({"R2 sgr ", e.tag}, sgr_o, e.sgr);
        chk({"R3 sr ", e.tag}, sr_o, e.sr);
        chk({"R4 evt ", e.tag}, {21'd0, evt_o}, {21'd0, e.evt});
        chk({"R5/R6/R7 pc ", e.tag}, pc_o, e.pc);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; raise_i = 1'b0; code_i = 12'h040;
    sr_i = 32'hFFFF_FFFF; pc_i = 32'h1234; vbr_i = 32'h8000_0000; r15_i = 32'h55;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 sr", sr_o, 0);   chk("R1 pc", pc_o, 0);   chk("R1 ssr", ssr_o, 0);
    chk("R1 spc", spc_o, 0); chk("R1 sgr", sgr_o, 0); chk("R1 evt", {21'd0, evt_o}, 0);
    chk("R1 taken", {31'd0, taken_o}, 0);
    rst_n = 1'b1;

    raise(12'h040, 32'h0000_00F0, 32'h0C00_1000, 32'h8C00_0000, 32'h1111_0001, "R5 miss rd");
    idle(1);
    raise(12'h060, 32'h0000_0001, 32'h0C00_1004, 32'h8C01_0000, 32'h1111_0002, "R5 miss wr");
    raise(12'h080, 32'h0000_0300, 32'h0C00_1008, 32'hFFFF_FE00, 32'h1111_0003, "R5 init wr wrap");
    raise(12'h140, 32'h4000_0000, 32'h0C00_100C, 32'h8C02_0000, 32'h1111_0004, "R6 multi");
    raise(12'h0E0, 32'h0000_0002, 32'h0C00_1010, 32'h8C03_0000, 32'h1111_0005, "R7 addr");
    raise(12'h180, 32'h0000_0000, 32'h0C00_1014, 32'h8C04_0000, 32'h1111_0006, "R7 illegal");
    raise(12'h1A0, 32'h8000_0001, 32'h0C00_1018, 32'h8C05_0000, 32'h1111_0007, "R7 slot ill");
    raise(12'h800, 32'h0000_8000, 32'h0C00_101C, 32'h8C06_0000, 32'h1111_0008, "R7 fpu dis");
    raise(12'h820, 32'h0000_0010, 32'h0C00_1020, 32'h8C07_0000, 32'h1111_0009, "R7 slot fpu");
    raise(12'h100, 32'h0000_0020, 32'h0C00_1024, 32'h8C08_0000, 32'h1111_000A, "R7 data wr");
    raise(12'h120, 32'h0000_0040, 32'h0C00_1028, 32'h8C09_0000, 32'h1111_000B, "R7 fpu exc");
    raise(12'h160, 32'h0000_0080, 32'h0C00_102C, 32'h8C0A_0000, 32'h1111_000C, "R7 trap");
    raise(12'h840, 32'h0000_0004, 32'h0C00_1030, 32'h8C0B_0000, 32'h1111_000D, "R4/R7 0x840");
    raise(12'hFFF, 32'hFFFF_FFFF, 32'h0C00_1034, 32'h8C0C_0000, 32'h1111_000E, "R4 0xFFF");
    raise(12'h0A0, 32'h1000_0000, 32'h0C00_1038, 32'h8C0D_0000, 32'h1111_000F, "R8 BL set");
    raise(12'h040, 32'h7000_0005, 32'h0C00_103C, 32'h8C0E_0000, 32'h1111_0010, "R8 all set");
    idle(5);
    // R9: idle cycles with changing inputs leave outputs as the last entry left them
    chk("R9 sr", sr_o, last.sr);     chk("R9 pc", pc_o, last.pc);
    chk("R9 ssr", ssr_o, last.ssr);  chk("R9 spc", spc_o, last.spc);
    chk("R9 sgr", sgr_o, last.sgr);  chk("R9 evt", {21'd0, evt_o}, {21'd0, last.evt});
    chk("R10 taken low when idle", {31'd0, taken_o}, 0);
    chk("R10 scoreboard drained", sb_q.size(), 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule